// File: doc/BRIEF.md
# Lookup-Table Entry Locator

This block turns a 16-bit table-call instruction into the memory address of the table entry it names. It holds the table's two user-level control registers: a base pointer and a count of wide entries. When the instruction word on its input carries the table-call encoding, the block extracts an 11-bit index. One clock later it presents the byte address of that entry, a flag that says whether the entry is 8 bytes or 4 bytes wide, and the index itself.

The table starts at a 64-byte-aligned base. It opens with a programmable number of 8-byte entries, and every entry after those is 4 bytes wide. A fetch unit placed downstream uses the address and the width flag to read the entry. Software reaches both registers through a simple CSR port, and reads are combinational.

Top module: `optbl_locator`

## Requirements
- R1: The base register sits at CSR address 0x800. Bits [XLEN-1:6] are writable and read back as written. Bits [5:0] always read 0.
- R2: The wide-count register sits at CSR address 0x801. Its 11-bit count is written from and read back in bits [13:3]. Every other bit reads 0.
- R3: After reset the count is 0. Every entry is then 4 bytes wide, and the address is base + 4 × index.
- R4: An instruction word is a table call only when bits [1:0] are 00 and bits [15:13] are 001. `loc_valid` is high in the cycle after a table call is presented, and low in the cycle after any other word.
- R5: `loc_index` equals bits [12:2] of the table-call word presented in the previous cycle.
- R6: When the index is below the count, `loc_addr` is base + 8 × index and `loc_wide` is 1.
- R7: When the index is equal to or above the count, `loc_addr` is base + 8 × count + 4 × (index − count) and `loc_wide` is 0.
- R8: The address is computed modulo 2^XLEN, so it wraps past the top of the address space.
- R9: After a word that is not a table call, `loc_addr`, `loc_wide` and `loc_index` keep their previous values.
- R10: A CSR address other than 0x800 or 0x801 reads 0, and a write to it changes neither register.
- R11: A table call presented in the same cycle as a count write uses the count held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_we | input | 1 | CSR write enable |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| insn | input | 16 | Instruction word to decode |
| loc_valid | output | 1 | Table call decoded in the previous cycle |
| loc_addr | output | XLEN | Byte address of the addressed entry |
| loc_wide | output | 1 | 1 = 8-byte entry, 0 = 4-byte entry |
| loc_index | output | 11 | Index of the addressed entry |

## Verification
A corrupted count register shows at the ports on the first table call after it. That call's width flag flips at the wide/narrow boundary, and the address is off by 4 bytes for each index the boundary has moved. A readback of 0x801 shows the fault at once. A stale or wrongly enabled output register shows up in the first cycle after a non-table word, as an address or index that changes when it should hold. A decode fault shows up one cycle after the word, as a wrong `loc_valid`. The scoreboard therefore compares every cycle with the model, and it probes both sides of the count boundary, the largest index and address wrap.

// File: rtl/optbl_pkg.sv
package optbl_pkg;
  localparam int unsigned CSR_AW    = 12;
  localparam int unsigned IDX_W     = 11;
  localparam int unsigned BASE_LSB  = 6;   // base alignment (64 bytes)
  localparam int unsigned CNT_LSB   = 3;   // count field position
  localparam int unsigned OFF_W     = IDX_W + 3;
  localparam logic [CSR_AW-1:0] CSR_BASE_ADR = 12'h800;
  localparam logic [CSR_AW-1:0] CSR_CNT_ADR  = 12'h801;
  localparam logic [2:0] CALL_FUNCT  = 3'b001;
  localparam logic [1:0] CALL_QUAD   = 2'b00;
endpackage

// File: rtl/optbl_csr.sv
module optbl_csr
  import optbl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CSR_AW-1:0]        csr_addr,
  input  logic [XLEN-1:0]          csr_wdata,
  input  logic                     csr_we,
  output logic [XLEN-1:0]          csr_rdata,
  output logic [XLEN-1:BASE_LSB]   base_o,
  output logic [IDX_W-1:0]         cnt_o
);
  logic [XLEN-1:BASE_LSB] base_q, base_d;
  logic [IDX_W-1:0]       cnt_q, cnt_d;
  logic                   base_en, cnt_en;
  logic                   unused_wdata_low;

  assign unused_wdata_low = ^csr_wdata[CNT_LSB-1:0];

  always_comb begin
    base_en = csr_we && (csr_addr == CSR_BASE_ADR);
    cnt_en  = csr_we && (csr_addr == CSR_CNT_ADR);
    base_d  = base_en ? csr_wdata[XLEN-1:BASE_LSB] : base_q;
    cnt_d   = cnt_en  ? csr_wdata[CNT_LSB+IDX_W-1:CNT_LSB] : cnt_q;
  end

  // base pointer has no defined reset value
  always_ff @(posedge clk) begin
    base_q <= base_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == CSR_BASE_ADR)
      csr_rdata[XLEN-1:BASE_LSB] = base_q;
    else if (csr_addr == CSR_CNT_ADR)
      csr_rdata[CNT_LSB+IDX_W-1:CNT_LSB] = cnt_q;
  end

  assign base_o = base_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/optbl_decode.sv
module optbl_decode
  import optbl_pkg::*;
(
  input  logic [15:0]      insn,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = (insn[1:0] == CALL_QUAD) && (insn[15:13] == CALL_FUNCT);
    idx = insn[2+IDX_W-1:2];
  end
endmodule

// File: rtl/optbl_offset.sv
module optbl_offset
  import optbl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:BASE_LSB] base,
  input  logic [IDX_W-1:0]       cnt,
  input  logic [IDX_W-1:0]       idx,
  output logic [XLEN-1:0]        addr,
  output logic                   wide
);
  localparam int unsigned PAD_W = XLEN - OFF_W;

  logic [OFF_W-1:0] off_wide, off_narrow, off;
  logic [IDX_W:0]   sum;

  always_comb begin
    wide       = idx < cnt;
    off_wide   = {idx, 3'b000};
    // 8*cnt + 4*(idx-cnt) == 4*(idx+cnt)
    sum        = {1'b0, idx} + {1'b0, cnt};
    off_narrow = {1'b0, sum, 2'b00};
    off        = wide ? off_wide : off_narrow;
    addr       = {base, {BASE_LSB{1'b0}}} + {{PAD_W{1'b0}}, off};
  end
endmodule

// File: rtl/optbl_locator.sv
module optbl_locator
  import optbl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic              csr_we,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic [15:0]       insn,
  output logic              loc_valid,
  output logic [XLEN-1:0]   loc_addr,
  output logic              loc_wide,
  output logic [10:0]       loc_index
);
  logic [1:0]             rst_sync_q;
  logic                   rst_sync_n;
  logic [XLEN-1:BASE_LSB] base_w;
  logic [IDX_W-1:0]       cnt_q;
  logic                   hit_w, wide_w;
  logic [IDX_W-1:0]       idx_w;
  logic [XLEN-1:0]        addr_w;

  logic                   valid_q, valid_d;
  logic [XLEN-1:0]        addr_q, addr_d;
  logic                   wide_q, wide_d;
  logic [IDX_W-1:0]       index_q, index_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  optbl_csr #(.XLEN(XLEN)) u_csr (
    .clk(clk), .rst_n(rst_sync_n),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_we(csr_we),
    .csr_rdata(csr_rdata), .base_o(base_w), .cnt_o(cnt_q)
  );

  optbl_decode u_dec (.insn(insn), .hit(hit_w), .idx(idx_w));

  optbl_offset #(.XLEN(XLEN)) u_off (
    .base(base_w), .cnt(cnt_q), .idx(idx_w), .addr(addr_w), .wide(wide_w)
  );

  always_comb begin
    valid_d = hit_w;
    addr_d  = hit_w ? addr_w : addr_q;
    wide_d  = hit_w ? wide_w : wide_q;
    index_d = hit_w ? idx_w  : index_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      wide_q  <= 1'b0;
      index_q <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      wide_q  <= wide_d;
      index_q <= index_d;
    end
  end

  assign loc_valid = valid_q;
  assign loc_addr  = addr_q;
  assign loc_wide  = wide_q;
  assign loc_index = index_q;
endmodule

// File: rtl/optbl_locator_chk.sv
module optbl_locator_chk
  import optbl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [11:0]       csr_addr,
  input logic [XLEN-1:0]   csr_rdata,
  input logic [15:0]       insn,
  input logic [IDX_W-1:0]  cnt,
  input logic              loc_valid,
  input logic [XLEN-1:0]   loc_addr,
  input logic              loc_wide,
  input logic [10:0]       loc_index
);
  logic armed;
  logic is_call;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign is_call = (insn[1:0] == 2'b00) && (insn[15:13] == 3'b001);

  always_comb begin
    if (rst_n && csr_addr == CSR_BASE_ADR)
      assert_base_lowzero_R1: assert (csr_rdata[BASE_LSB-1:0] == '0);
    if (rst_n && csr_addr == CSR_CNT_ADR)
      assert_cnt_rsvd_R2: assert (csr_rdata[CNT_LSB-1:0] == '0 &&
                                  (csr_rdata >> (CNT_LSB + IDX_W)) == '0);
  end

  assert_cnt_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> cnt == '0);

  assert_valid_latency_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    loc_valid == $past(is_call));

  assert_index_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    loc_valid |-> loc_index == $past(insn[12:2]));

  assert_wide_sel_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    loc_valid |-> loc_wide == ($past(insn[12:2]) < $past(cnt)));

  assert_wide_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && loc_wide) |-> loc_addr[2:0] == 3'b000);

  assert_narrow_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid |-> loc_addr[1:0] == 2'b00);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_call |=> $stable(loc_addr) && $stable(loc_wide) && $stable(loc_index));
endmodule

bind optbl_locator optbl_locator_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .csr_addr(csr_addr), .csr_rdata(csr_rdata),
  .insn(insn), .cnt(cnt_q), .loc_valid(loc_valid), .loc_addr(loc_addr),
  .loc_wide(loc_wide), .loc_index(loc_index)
);

// File: tb/optbl_locator_test.sv
module optbl_locator_test;
  localparam int XLEN = 32;

  logic            clk;
  logic            rst_n;
  logic [11:0]     csr_addr;
  logic [XLEN-1:0] csr_wdata;
  logic            csr_we;
  logic [XLEN-1:0] csr_rdata;
  logic [15:0]     insn;
  logic            loc_valid;
  logic [XLEN-1:0] loc_addr;
  logic            loc_wide;
  logic [10:0]     loc_index;

  optbl_locator #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(csr_rdata), .insn(insn), .loc_valid(loc_valid),
    .loc_addr(loc_addr), .loc_wide(loc_wide), .loc_index(loc_index)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  typedef struct {
    logic        vld;
    logic [31:0] addr;
    logic        wide;
    logic [10:0] idx;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] m_base = '0;
  int          m_cnt  = 0;
  logic [31:0] last_addr = '0;
  logic        last_wide = 1'b0;
  logic [10:0] last_idx  = '0;
  bit          done = 0;

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_addr(logic [31:0] base, int cnt, int i);
    if (i < cnt) return base + 32'(i * 8);
    return base + 32'(cnt * 8) + 32'((i - cnt) * 4);
  endfunction

  task automatic csr_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    insn = 16'h0000; csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    if (a == 12'h800) m_base = d & 32'hFFFF_FFC0;
    if (a == 12'h801) m_cnt  = int'(d[13:3]);
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    insn = 16'h0000; csr_we = 1'b0; csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic push_call(int i, int cnt_used, string tag);
    exp_t e;
    e.vld = 1'b1; e.idx = 11'(i); e.wide = (i < cnt_used);
    e.addr = model_addr(m_base, cnt_used, i); e.tag = tag;
    last_addr = e.addr; last_wide = e.wide; last_idx = e.idx;
    sb.push_back(e);
  endtask

  task automatic issue(int i, string tag);
    @(negedge clk);
    insn = {3'b001, 11'(i), 2'b00};
    push_call(i, m_cnt, tag);
  endtask

  task automatic issue_other(logic [15:0] w, string tag);
    exp_t e;
    @(negedge clk);
    insn = w;
    e.vld = 1'b0; e.addr = last_addr; e.wide = last_wide; e.idx = last_idx; e.tag = tag;
    sb.push_back(e);
  endtask

  // call and count write in the same cycle (R11)
  task automatic issue_with_cnt_write(int i, logic [31:0] d);
    int old_cnt;
    @(negedge clk);
    old_cnt = m_cnt;
    insn = {3'b001, 11'(i), 2'b00};
    csr_addr = 12'h801; csr_wdata = d; csr_we = 1'b1;
    push_call(i, old_cnt, "R11");
    m_cnt = int'(d[13:3]);
    @(negedge clk);
    csr_we = 1'b0; insn = 16'h0000;
  endtask

  // monitor: compares each result with the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(loc_valid == e.vld, e.tag, "valid", 32'(loc_valid), 32'(e.vld));
        check(loc_addr == e.addr, e.tag, "addr", loc_addr, e.addr);
        check(loc_wide == e.wide, e.tag, "wide", 32'(loc_wide), 32'(e.wide));
        check(loc_index == e.idx, e.tag, "index", 32'(loc_index), 32'(e.idx));
      end
    end
  end

  initial begin
    for (int n = 0; n < 20000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; csr_addr = '0; csr_wdata = '0; csr_we = 1'b0; insn = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check(loc_valid == 1'b0, "R4", "valid after reset", 32'(loc_valid), 32'd0);
    csr_read(12'h801, rd);
    check(rd == 32'd0, "R3", "count after reset", rd, 32'd0);

    // base register: low six bits read zero
    csr_write(12'h800, 32'h1234_5678);
    csr_read(12'h800, rd);
    check(rd == 32'h1234_5640, "R1", "base readback", rd, 32'h1234_5640);

    // count still 0: all narrow
    issue(5, "R3");
    issue(0, "R3");
    issue_other(16'h0000, "R9");

    // count register field and reserved bits
    csr_write(12'h801, 32'hFFFF_FFFF);
    csr_read(12'h801, rd);
    check(rd == 32'h0000_3FF8, "R2", "count readback", rd, 32'h0000_3FF8);

    // unmapped address
    csr_write(12'h802, 32'hDEAD_BEEF);
    csr_read(12'h802, rd);
    check(rd == 32'd0, "R10", "unmapped read", rd, 32'd0);
    csr_read(12'h800, rd);
    check(rd == 32'h1234_5640, "R10", "base unchanged", rd, 32'h1234_5640);
    csr_read(12'h801, rd);
    check(rd == 32'h0000_3FF8, "R10", "count unchanged", rd, 32'h0000_3FF8);

    // count 2047: boundary at the top
    issue(2046, "R6");
    issue(2047, "R7");

    // count 10: both sides of the boundary
    csr_write(12'h801, 32'd10 << 3);
    issue(0, "R6");
    issue(9, "R6");
    issue(10, "R7");
    issue(11, "R7");
    issue(2047, "R7");
    issue(1234, "R5");
    issue_other(16'h2001, "R4");   // quadrant 01
    issue_other(16'h4000, "R4");   // funct 010
    issue_other(16'hFFFF, "R9");
    issue(7, "R6");
    issue_other(16'h2003, "R9");   // funct ok, quadrant 11

    // wrap past the top of the address space
    csr_write(12'h800, 32'hFFFF_FFC0);
    csr_write(12'h801, 32'd0);
    issue(100, "R8");
    csr_write(12'h801, 32'd2047 << 3);
    issue(1000, "R8");
    issue(2047, "R8");

    // same-cycle count write
    csr_write(12'h801, 32'd0);
    csr_write(12'h800, 32'h0000_1000);
    issue_with_cnt_write(3, 32'd5 << 3);
    issue(3, "R11");
    issue_other(16'h0000, "R9");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule